// File: doc/BRIEF.md
# SIMD Shift-Right-and-Insert Unit

This block performs a packed-SIMD "shift right and insert" by an immediate amount. A 7-bit immediate is split into a 4-bit high part and a 3-bit low part. The position of the leading one in the high part selects the lane width. The whole 7-bit value, subtracted from twice the lane width, gives the shift distance. Each lane of the source vector is shifted right logically. The shifted value is then merged into the matching lane of the current destination vector: only the low bits that receive shifted data change, and the top `shift` bits of each destination lane keep their old value.

Two classes are supported. The vector class covers a 64-bit or 128-bit datapath, chosen by a width-select bit. The scalar class always works on one 64-bit lane. Encodings that the operation does not define raise an undefined flag instead of a valid result. Results are registered, so the latency is one clock cycle. That latency never depends on the operand values.

Top module: `simd_sri_unit`

## Requirements
- R1: Lane width decodes from the immediate's high part `imm[6:3]`: a leading one at bit 6 selects 64 bits, at bit 5 selects 32, at bit 4 selects 16, and at bit 3 selects 8.
- R2: The shift distance is twice the lane width minus the unsigned value of `imm[6:0]`, which gives a distance from 1 up to the lane width.
- R3: For each lane, result bit k equals source bit k+shift of the same lane when k < width-shift; otherwise it equals destination bit k.
- R4: When the shift equals the lane width, the destination lane passes through unchanged and no source bit appears in it.
- R5: In the vector class with `wide_q`=0, the datapath is 64 bits and result bits 127:64 are zero; with `wide_q`=1 all 128 bits are processed.
- R6: In the vector class, an immediate with `imm[6:3]`=0000, or with `imm[6]`=1 while `wide_q`=0, is undefined.
- R7: In the scalar class, `imm[6]` must be 1 and the operation covers one 64-bit lane with result bits 127:64 zero. Any scalar immediate with `imm[6]`=0 is undefined.
- R8: One cycle after an accepted request (`in_valid`=1), `res_valid` is 1 for a defined encoding and `undef_enc` is 1 for an undefined one, never both. `res_vec` is zero when the encoding is undefined. With `in_valid`=0 both flags are 0 on the next cycle.
- R9: A synchronous reset clears `res_valid`, `undef_enc` and `res_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| scalar_sel | input | 1 | 1 = scalar class, 0 = vector class |
| wide_q | input | 1 | Vector class: 1 = 128-bit datapath, 0 = 64-bit |
| imm | input | 7 | Packed immediate: bits 6:3 high part, bits 2:0 low part |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Current destination vector |
| res_vec | output | 128 | Merged result, registered |
| res_valid | output | 1 | Result is valid, registered |
| undef_enc | output | 1 | Request had an undefined encoding, registered |

## Verification
All 128 immediates are swept for both classes and both width selections, so every lane width, every shift distance and every undefined corner is hit. This sweep is repeated with three operand patterns. An all-ones source over a zero destination exposes exactly which low bits the mask opens. A zero source over an all-ones destination shows that the kept top bits survive. Per-run pseudo-random data tells a correct in-lane shift apart from bits leaking across lane borders or from the wrong shift direction. Idle cycles and reset confirm the flags are driven only by accepted requests.

// File: rtl/sri_pkg.sv
package sri_pkg;
  localparam int VEC_W = 128;
  localparam int IMM_W = 7;
  localparam int SH_W  = 7;
  localparam int HALF_W = VEC_W / 2;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2,
    LW_64 = 2'd3
  } lane_sz_t;
endpackage

// File: rtl/sri_decode.sv
module sri_decode
  import sri_pkg::*;
#(
  parameter int IMM_BITS = IMM_W,
  parameter int SH_BITS  = SH_W
) (
  input  logic [IMM_BITS-1:0] imm,
  input  logic                wide_q,
  input  logic                scalar_sel,
  output lane_sz_t            lane_sz,
  output logic [SH_BITS-1:0]  shamt,
  output logic                full_width,
  output logic                undef
);
  localparam int HI_W = IMM_BITS - 3;
  localparam int EXT_W = SH_BITS + 1;

  logic [HI_W-1:0]   hi;
  logic [EXT_W-1:0]  twice_w;
  logic [EXT_W-1:0]  diff;

  assign hi = imm[IMM_BITS-1:3];

  always_comb begin
    if (hi[3])      lane_sz = LW_64;
    else if (hi[2]) lane_sz = LW_32;
    else if (hi[1]) lane_sz = LW_16;
    else            lane_sz = LW_8;
  end

  assign twice_w = EXT_W'(16) << lane_sz;
  assign diff    = twice_w - EXT_W'(imm);
  assign shamt   = diff[SH_BITS-1:0];

  always_comb begin
    if (scalar_sel) undef = ~hi[3];
    else            undef = (hi == '0) | (hi[3] & ~wide_q);
  end

  assign full_width = ~scalar_sel & wide_q;

  always_comb begin
    if (!undef) begin
      // R2
      sh_range_chk: assert (shamt >= 1 && shamt <= (SH_BITS'(8) << lane_sz));
    end
  end
endmodule

// File: rtl/sri_lane.sv
module sri_lane #(
  parameter int LW      = 8,
  parameter int SH_BITS = 7
) (
  input  logic [LW-1:0]      s,
  input  logic [LW-1:0]      d,
  input  logic [SH_BITS-1:0] sh,
  output logic [LW-1:0]      y
);
  logic [LW-1:0] mask;
  logic [LW-1:0] shifted;

  // shifts of LW or more give zero, never wrap
  assign mask    = {LW{1'b1}} >> sh;
  assign shifted = s >> sh;
  assign y       = (d & ~mask) | shifted;

  always_comb begin
    if (int'(sh) == LW) begin
      // R4
      full_shift_chk: assert (y == d);
    end
  end
endmodule

// File: rtl/sri_datapath.sv
module sri_datapath
  import sri_pkg::*;
#(
  parameter int DW      = VEC_W,
  parameter int SH_BITS = SH_W
) (
  input  logic [DW-1:0]      src,
  input  logic [DW-1:0]      dst,
  input  lane_sz_t           lane_sz,
  input  logic [SH_BITS-1:0] shamt,
  input  logic               full_width,
  output logic [DW-1:0]      merged
);
  localparam int NSZ = 4;
  localparam int HW  = DW / 2;

  logic [DW-1:0] cand [NSZ];
  logic [DW-1:0] sel;

  for (genvar z = 0; z < NSZ; z++) begin : g_sz
    localparam int LW = 8 << z;
    localparam int NL = DW / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      sri_lane #(.LW(LW), .SH_BITS(SH_BITS)) u_lane (
        .s  (src[l*LW +: LW]),
        .d  (dst[l*LW +: LW]),
        .sh (shamt),
        .y  (cand[z][l*LW +: LW])
      );
    end
  end

  assign sel    = cand[lane_sz];
  assign merged = full_width ? sel : {{HW{1'b0}}, sel[HW-1:0]};
endmodule

// File: rtl/simd_sri_unit.sv
module simd_sri_unit
  import sri_pkg::*;
#(
  parameter int DW       = VEC_W,
  parameter int IMM_BITS = IMM_W,
  parameter int SH_BITS  = SH_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                scalar_sel,
  input  logic                wide_q,
  input  logic [IMM_BITS-1:0] imm,
  input  logic [DW-1:0]       src_vec,
  input  logic [DW-1:0]       dst_vec,
  output logic [DW-1:0]       res_vec,
  output logic                res_valid,
  output logic                undef_enc
);
  localparam int HW = DW / 2;

  lane_sz_t           lane_sz;
  logic [SH_BITS-1:0] shamt;
  logic               full_width;
  logic               undef;
  logic [DW-1:0]      merged;

  sri_decode #(.IMM_BITS(IMM_BITS), .SH_BITS(SH_BITS)) u_dec (
    .imm        (imm),
    .wide_q     (wide_q),
    .scalar_sel (scalar_sel),
    .lane_sz    (lane_sz),
    .shamt      (shamt),
    .full_width (full_width),
    .undef      (undef)
  );

  sri_datapath #(.DW(DW), .SH_BITS(SH_BITS)) u_dp (
    .src        (src_vec),
    .dst        (dst_vec),
    .lane_sz    (lane_sz),
    .shamt      (shamt),
    .full_width (full_width),
    .merged     (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vec   <= '0;
      res_valid <= 1'b0;
      undef_enc <= 1'b0;
    end else begin
      res_valid <= in_valid & ~undef;
      undef_enc <= in_valid & undef;
      res_vec   <= (in_valid && !undef) ? merged : '0;
    end
  end

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && undef_enc));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !undef_enc));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!res_valid && !undef_enc && res_vec == '0));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(wide_q && !scalar_sel)) |=> (res_vec[DW-1:HW] == '0));

  // R7
  scalar_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar_sel && !imm[IMM_BITS-1]) |=> undef_enc);

  // R6
  vec_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !scalar_sel && imm[IMM_BITS-1] && !wide_q) |=> undef_enc);
endmodule

// File: tb/tb_simd_sri_unit.sv
module tb_simd_sri_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         scalar_sel = 1'b0;
  logic         wide_q = 1'b0;
  logic [6:0]   imm = '0;
  logic [127:0] src_vec = '0;
  logic [127:0] dst_vec = '0;
  logic [127:0] res_vec;
  logic         res_valid;
  logic         undef_enc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  simd_sri_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .scalar_sel(scalar_sel),
    .wide_q(wide_q), .imm(imm), .src_vec(src_vec), .dst_vec(dst_vec),
    .res_vec(res_vec), .res_valid(res_valid), .undef_enc(undef_enc)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] d,
                                         input logic [6:0] im, input bit q, input bit sc,
                                         output bit ud, output int esz, output int sh);
    logic [127:0] r = '0;
    int width;
    logic [3:0] hi = im[6:3];
    esz = hi[3] ? 64 : hi[2] ? 32 : hi[1] ? 16 : 8;
    sh  = 2 * esz - int'(im);
    ud  = sc ? !hi[3] : (hi == 0 || (hi[3] && !q));
    width = (sc || !q) ? 64 : 128;
    if (ud) return '0;
    for (int b = 0; b < width; b++) begin
      int k = b % esz;
      if (k >= esz - sh) r[b] = d[b];
      else               r[b] = s[b + sh];
    end
    return r;
  endfunction

  task automatic run_one(input logic [127:0] s, input logic [127:0] d,
                         input logic [6:0] im, input bit q, input bit sc);
    logic [127:0] exp;
    bit ud;
    int esz, sh;
    string tg;
    exp = model(s, d, im, q, sc, ud, esz, sh);
    @(negedge clk);
    in_valid = 1'b1; src_vec = s; dst_vec = d; imm = im; wide_q = q; scalar_sel = sc;
    @(negedge clk);
    in_valid = 1'b0;
    if (ud) begin
      chk(undef_enc == 1'b1 && res_valid == 1'b0, sc ? "R7 undefined scalar" : "R6 undefined vector",
          {126'd0, res_valid, undef_enc}, 128'd1);
      chk(res_vec == '0, "R8 zero result when undefined", res_vec, '0);
    end else begin
      chk(res_valid == 1'b1 && undef_enc == 1'b0, "R8 valid flag",
          {126'd0, res_valid, undef_enc}, 128'd2);
      if (sc)            tg = "R7 scalar lane";
      else if (sh == esz) tg = "R4 full shift passthrough";
      else               tg = "R1 R2 R3 lane merge";
      chk(res_vec == exp, tg, res_vec, exp);
      if (sc || !q) chk(res_vec[127:64] == '0, "R5 upper half zero", res_vec, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(res_valid == 0 && undef_enc == 0 && res_vec == '0, "R9 reset state",
        res_vec, '0);
    rst = 1'b0;
    @(negedge clk);
    // R8: idle produces no flags
    chk(res_valid == 0 && undef_enc == 0, "R8 idle flags",
        {126'd0, res_valid, undef_enc}, '0);

    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 2; c++) begin
        for (int q = 0; q < 2; q++) begin
          for (int i = 0; i < 128; i++) begin
            logic [127:0] s, d;
            if (p == 0) begin s = '1; d = '0; end
            else if (p == 1) begin s = '0; d = '1; end
            else begin
              s = {$urandom, $urandom, $urandom, $urandom};
              d = {$urandom, $urandom, $urandom, $urandom};
            end
            run_one(s, d, 7'(i), q[0], c[0]);
          end
        end
      end
    end

    // R4 directed: 8-bit lanes, shift 8 (imm=8) leaves destination untouched
    run_one({16{8'hA5}}, {16{8'h3C}}, 7'd8, 1'b1, 1'b0);
    chk(res_vec == {16{8'h3C}}, "R4 directed passthrough", res_vec, {16{8'h3C}});
    // R3 directed: 8-bit lanes, shift 3 (imm=13): top 3 bits kept
    run_one({16{8'hFF}}, {16{8'h00}}, 7'd13, 1'b1, 1'b0);
    chk(res_vec == {16{8'h1F}}, "R3 directed shift by 3", res_vec, {16{8'h1F}});

    // R9: reset clears a pending result
    @(negedge clk);
    in_valid = 1'b1; scalar_sel = 1'b0; wide_q = 1'b1; imm = 7'd13; src_vec = '1;
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(res_valid == 0 && undef_enc == 0 && res_vec == '0, "R9 reset clears", res_vec, '0);
    rst = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule